// File: doc/BRIEF.md
# Flash Single-Word Program Port

This block is the write side of a memory-mapped slave in front of a small flash array model. A master presents an address, one 32-bit data word and a burst count with a write strobe. If the port is idle, the request is taken in that same cycle. The port then checks three things: the burst count, whether the address falls inside the array, and whether the write-protect bit of the sector holding that address is clear. The protect bits come from a separate control register.

A request that passes all three checks starts a program operation. Waitrequest stays high for a busy time set by a parameter, and the busy code reads 2'b10. When the time runs out, the array word becomes the bitwise AND of its old value and the new data, so programming can only clear bits; setting a bit again needs an erase, which is outside this block. A request that fails any check finishes after a single busy cycle and leaves the array untouched. Either way, the result is reported through a write-ok status flag rather than on the bus.

A combinational read port exposes the array contents so that the effect of each program operation can be seen.

Top module: `flash_word_programmer`

## Requirements
- R1: After reset, waitrequest is 0, the busy code is 2'b00, the write-ok flag is 0, and every word of the array reads 32'hFFFF_FFFF.
- R2: A write is accepted in a cycle where write is 1 and waitrequest is 0. For a valid request, waitrequest is high for exactly PROG_CYCLES cycles following the accepting cycle, and the busy code is 2'b10 in each of those cycles.
- R3: When a valid program completes, the addressed word becomes the old word AND writedata. A bit that is already 0 never returns to 1.
- R4: The write-ok flag changes only when an operation completes. It reads 1 from the first idle cycle after a valid program until the next completion.
- R5: A request whose burstcount is not 1 is rejected: waitrequest is high for exactly one cycle, write-ok becomes 0, and the array is unchanged.
- R6: A request whose address is at or above the array depth (40 words by default) is rejected in the same way as R5.
- R7: A request whose target sector has its write_protect bit set to 1 is rejected in the same way as R5. Bit i of write_protect guards sector i.
- R8: Sector membership is decided by parameterized exclusive upper bounds. By default these are sector 0 = [0,8), sector 1 = [8,24) and sector 2 = [24,40), so addresses 7/8 and 23/24 fall into different sectors.
- R9: Write strobes presented while waitrequest is high are not accepted, and the array word they address is unchanged.
- R10: rd_data returns the stored word at rd_addr in the same cycle, and returns 32'hFFFF_FFFF for an rd_addr outside the array.
- R11: The protect bits are sampled only in the accepting cycle. Changing them during a program operation does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| address | input | ADDR_W | Word address of the program request |
| write | input | 1 | Write strobe |
| writedata | input | DATA_W | Data word to program |
| burstcount | input | BC_W | Burst count; must be 1 |
| write_protect | input | NUM_SECTORS | Per-sector protect bits; 1 blocks programming |
| waitrequest | output | 1 | High while an operation is in progress |
| busy_code | output | 2 | 2'b00 idle, 2'b10 programming |
| write_ok | output | 1 | Result of the last completed operation |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | DATA_W | Stored word at rd_addr |

## Verification
Several properties are checked by the assertions on every cycle:
- waitrequest rises only in response to a write strobe;
- the latched request stays stable while busy;
- a reject lasts exactly one busy cycle;
- the write-ok flag moves only when an operation completes;
- a programmed word never holds a 1 where the data had a 0;
- every in-range address falls into exactly one sector.

Other behaviours can only be shown by the bench scenarios: the exact busy length, the AND result over repeated programs, each rejection reason at the sector edges, strobes ignored during busy, and protect bits changed in mid-operation.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    localparam logic [1:0] BUSY_IDLE = 2'b00;
    localparam logic [1:0] BUSY_PROG = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_REJ  = 2'd2
    } prog_state_e;

    typedef struct packed {
        logic burst_ok;
        logic range_ok;
        logic unlocked;
    } verdict_t;

    function automatic logic verdict_pass(verdict_t v);
        return v.burst_ok && v.range_ok && v.unlocked;
    endfunction

endpackage

// File: rtl/flash_prog_check.sv
module flash_prog_check
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BC_W        = 8,
    parameter int NUM_SECTORS = 3,
    parameter logic [NUM_SECTORS*ADDR_W-1:0] SEC_BOUNDS = {8'd40, 8'd24, 8'd8}
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      address,
    input  logic [BC_W-1:0]        burstcount,
    input  logic [NUM_SECTORS-1:0] write_protect,
    output verdict_t               verdict
);

    logic [NUM_SECTORS-1:0] in_sec;

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sec
        localparam logic [ADDR_W-1:0] HI = SEC_BOUNDS[i*ADDR_W +: ADDR_W];
        if (i == 0) begin : g_first
            assign in_sec[i] = (address < HI);
        end else begin : g_rest
            localparam logic [ADDR_W-1:0] LO = SEC_BOUNDS[(i-1)*ADDR_W +: ADDR_W];
            assign in_sec[i] = (address >= LO) && (address < HI);
        end
    end

    always_comb begin
        verdict.burst_ok = (burstcount == BC_W'(1));
        verdict.range_ok = |in_sec;
        verdict.unlocked = |(in_sec & ~write_protect);
    end

    // R8: sectors never overlap
    p_one_sector_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_sec));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int PROG_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              write,
    input  logic [ADDR_W-1:0] address,
    input  logic [DATA_W-1:0] writedata,
    input  verdict_t          verdict,
    output logic              waitrequest,
    output logic [1:0]        busy_code,
    output logic              write_ok,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    prog_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept      = write && (state == ST_IDLE);
    assign waitrequest = (state != ST_IDLE);
    assign busy_code   = (state == ST_IDLE) ? BUSY_IDLE : BUSY_PROG;
    assign commit      = (state == ST_PROG) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            write_ok    <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    commit_addr <= address;
                    commit_data <= writedata;
                    cnt         <= CNT_W'(PROG_CYCLES - 1);
                    state       <= verdict_pass(verdict) ? ST_PROG : ST_REJ;
                end
                ST_PROG: if (cnt == '0) begin
                    write_ok <= 1'b1;
                    state    <= ST_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_REJ: begin
                    write_ok <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: busy only starts from a write strobe
    p_busy_from_write_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(waitrequest) |-> $past(write));

    // R9: latched request is frozen while busy
    p_hold_request_r9: assert property (@(posedge clk) disable iff (rst)
        (waitrequest && $past(waitrequest)) |-> ($stable(commit_addr) && $stable(commit_data)));

    // R5: a rejected request is busy for one cycle only
    p_reject_short_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJ) |=> !waitrequest);

    // R4: result flag moves only at completion
    p_flag_at_end_r4: assert property (@(posedge clk) disable iff (rst)
        (write_ok != $past(write_ok)) |-> ($past(waitrequest) && !waitrequest));

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rd_data = (rd_addr < ADDR_W'(DEPTH)) ? mem[rd_addr] : '1;

    // R3: a programmed word carries no 1 where the data had a 0
    p_clear_only_r3: assert property (@(posedge clk) disable iff (rst)
        commit |=> ((mem[$past(waddr)] & ~$past(wdata)) == '0));

endmodule

// File: rtl/flash_word_programmer.sv
module flash_word_programmer
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int BC_W        = 8,
    parameter int NUM_SECTORS = 3,
    parameter logic [NUM_SECTORS*ADDR_W-1:0] SEC_BOUNDS = {8'd40, 8'd24, 8'd8},
    parameter int PROG_CYCLES = 5000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      address,
    input  logic                   write,
    input  logic [DATA_W-1:0]      writedata,
    input  logic [BC_W-1:0]        burstcount,
    input  logic [NUM_SECTORS-1:0] write_protect,
    output logic                   waitrequest,
    output logic [1:0]             busy_code,
    output logic                   write_ok,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data
);

    localparam int DEPTH = int'(SEC_BOUNDS[(NUM_SECTORS-1)*ADDR_W +: ADDR_W]);

    verdict_t          verdict;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;

    flash_prog_check #(
        .ADDR_W(ADDR_W), .BC_W(BC_W), .NUM_SECTORS(NUM_SECTORS), .SEC_BOUNDS(SEC_BOUNDS)
    ) u_check (
        .clk(clk), .rst(rst), .address(address), .burstcount(burstcount),
        .write_protect(write_protect), .verdict(verdict)
    );

    flash_prog_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .write(write), .address(address), .writedata(writedata),
        .verdict(verdict), .waitrequest(waitrequest), .busy_code(busy_code),
        .write_ok(write_ok), .commit(commit), .commit_addr(commit_addr),
        .commit_data(commit_data)
    );

    flash_word_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_array (
        .clk(clk), .rst(rst), .commit(commit), .waddr(commit_addr), .wdata(commit_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: tb/flash_word_programmer_bench.sv
module flash_word_programmer_bench;

    localparam int P = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  address = '0;
    logic        write = 1'b0;
    logic [31:0] writedata = '0;
    logic [7:0]  burstcount = 8'd1;
    logic [2:0]  write_protect = '0;
    logic        waitrequest;
    logic [1:0]  busy_code;
    logic        write_ok;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    flash_word_programmer #(.PROG_CYCLES(P)) u_flash_word_programmer (
        .clk(clk), .rst(rst), .address(address), .write(write), .writedata(writedata),
        .burstcount(burstcount), .write_protect(write_protect), .waitrequest(waitrequest),
        .busy_code(busy_code), .write_ok(write_ok), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(rd_data === exp, req, rd_data, exp);
    endtask

    // issue one request; return busy cycle count and whether busy code was 10 throughout
    task automatic prog(input logic [7:0] a, input logic [31:0] d, input logic [7:0] bc,
                        output int n, output bit code_ok);
        @(negedge clk);
        address = a; writedata = d; burstcount = bc; write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        write = 1'b0;
        n = 0; code_ok = 1'b1;
        while (waitrequest && n < 10*P) begin
            if (busy_code !== 2'b10) code_ok = 1'b0;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(waitrequest === 1'b0, "R1 waitrequest", 32'(waitrequest), 0);
        chk(busy_code === 2'b00, "R1 busy_code", 32'(busy_code), 0);
        chk(write_ok === 1'b0, "R1 write_ok", 32'(write_ok), 0);
        rd_chk(8'd0, 32'hFFFF_FFFF, "R1 word 0");
        rd_chk(8'd39, 32'hFFFF_FFFF, "R1 word 39");
    endtask

    task automatic t_basic;
        int n; bit c;
        prog(8'd3, 32'hF0F0_1234, 8'd1, n, c);
        chk(n == P, "R2 busy length", 32'(n), 32'(P));
        chk(c, "R2 busy code 10", 32'(c), 1);
        chk(write_ok === 1'b1, "R4 write_ok after program", 32'(write_ok), 1);
        rd_chk(8'd3, 32'hF0F0_1234, "R3 first program");
    endtask

    task automatic t_and;
        int n; bit c;
        prog(8'd3, 32'h0FFF_FF00, 8'd1, n, c);
        rd_chk(8'd3, 32'h00F0_1200, "R3 AND with old word");
        prog(8'd3, 32'hFFFF_FFFF, 8'd1, n, c);
        rd_chk(8'd3, 32'h00F0_1200, "R3 zero bits stay zero");
        chk(write_ok === 1'b1, "R4 write_ok", 32'(write_ok), 1);
    endtask

    task automatic t_burst;
        int n; bit c;
        prog(8'd5, 32'h0, 8'd2, n, c);
        chk(n == 1, "R5 reject length", 32'(n), 1);
        chk(write_ok === 1'b0, "R5 write_ok cleared", 32'(write_ok), 0);
        rd_chk(8'd5, 32'hFFFF_FFFF, "R5 array untouched bc=2");
        prog(8'd5, 32'h0, 8'd0, n, c);
        rd_chk(8'd5, 32'hFFFF_FFFF, "R5 array untouched bc=0");
    endtask

    task automatic t_range;
        int n; bit c;
        prog(8'd40, 32'h0, 8'd1, n, c);
        chk(n == 1 && write_ok === 1'b0, "R6 addr 40 rejected", 32'(n), 1);
        prog(8'd200, 32'h0, 8'd1, n, c);
        chk(n == 1 && write_ok === 1'b0, "R6 addr 200 rejected", 32'(n), 1);
        prog(8'd39, 32'h0000_FFFF, 8'd1, n, c);
        chk(write_ok === 1'b1, "R8 addr 39 last word", 32'(write_ok), 1);
        rd_chk(8'd39, 32'h0000_FFFF, "R8 addr 39 data");
    endtask

    task automatic t_protect;
        int n; bit c;
        write_protect = 3'b010;
        prog(8'd8, 32'h0, 8'd1, n, c);
        chk(n == 1 && write_ok === 1'b0, "R7 addr 8 protected", 32'(write_ok), 0);
        rd_chk(8'd8, 32'hFFFF_FFFF, "R7 addr 8 untouched");
        prog(8'd23, 32'h0, 8'd1, n, c);
        chk(write_ok === 1'b0, "R7 addr 23 protected", 32'(write_ok), 0);
        prog(8'd7, 32'h1234_5678, 8'd1, n, c);
        chk(write_ok === 1'b1, "R8 addr 7 in sector 0", 32'(write_ok), 1);
        rd_chk(8'd7, 32'h1234_5678, "R8 addr 7 data");
        prog(8'd24, 32'hA5A5_A5A5, 8'd1, n, c);
        chk(write_ok === 1'b1, "R8 addr 24 in sector 2", 32'(write_ok), 1);
        rd_chk(8'd24, 32'hA5A5_A5A5, "R8 addr 24 data");
        write_protect = 3'b000;
    endtask

    task automatic t_busy_ignore;
        int n;
        @(negedge clk);
        address = 8'd12; writedata = 32'hCAFE_0000; burstcount = 8'd1; write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        address = 8'd13; writedata = 32'h0; write = 1'b1;
        @(negedge clk);
        @(negedge clk);
        write = 1'b0;
        n = 0;
        while (waitrequest && n < 10*P) begin n++; @(negedge clk); end
        rd_chk(8'd13, 32'hFFFF_FFFF, "R9 strobe during busy ignored");
        rd_chk(8'd12, 32'hCAFE_0000, "R9 original request done");
    endtask

    task automatic t_wp_sample;
        int n;
        @(negedge clk);
        address = 8'd10; writedata = 32'h0000_BEEF; burstcount = 8'd1; write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        write = 1'b0; write_protect = 3'b111;
        n = 0;
        while (waitrequest && n < 10*P) begin n++; @(negedge clk); end
        chk(write_ok === 1'b1, "R11 late protect ignored", 32'(write_ok), 1);
        rd_chk(8'd10, 32'h0000_BEEF, "R11 data written");
        write_protect = 3'b000;
    endtask

    task automatic t_read;
        rd_chk(8'd100, 32'hFFFF_FFFF, "R10 out of range read");
        rd_chk(8'd24, 32'hA5A5_A5A5, "R10 stored word read");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_and();
        t_burst();
        t_range();
        t_protect();
        t_busy_ignore();
        t_wp_sample();
        t_read();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule